// File: doc/BRIEF.md
# Control Endpoint Transfer Sequencer

This block steers the stages of a control transfer on endpoint 0 of a USB device controller. A packet engine reports single-cycle events to it: a setup packet has arrived (with its byte count), a data packet has arrived (with its byte count), the transmit buffer has drained, the host aborted the running transfer with a new setup, and a stall handshake went out. The sequencer answers with one-cycle command strobes: acknowledge the setup packet, mark a packet ready to send, acknowledge a received packet, end the data or status stage, send a stall, and clear the stall flag. It also drives a level that tells the engine which way the data stage runs.

A request decoder outside the block classifies each setup packet in the same cycle that the packet is reported, through a two-bit verdict. A function layer hands over one buffer at a time (its length, and whether an IN transfer that ends on a full packet must close with a zero-length packet), and it releases a held-off status stage. The sequencer cuts IN data into packets, counts OUT data against the buffer, decides when each stage ends and applies the stall rules. All command outputs come from registers, so every answer appears in the cycle after the event that caused it.

Top module: `ctrl_ep_seq`

## Requirements
- R1: After reset the stage output is SETUP (code 0), every command strobe and completion output is low and the direction level is low.
- R2: A setup event is acted on only in the SETUP stage and only when its byte count equals 8; any other count leaves the stage unchanged and produces no strobe.
- R3: A setup packet whose 16-bit length field is zero and whose verdict is 0 (handled) gives setup-acknowledge and data-end together in the next cycle, and the stage stays SETUP.
- R4: A setup packet with a nonzero length field and a verdict of 0 or 1 gives setup-acknowledge; bit 7 of the request type (the `setup_dir_in` input) set selects stage TX (code 1) and drives the direction level high, cleared selects stage RX (code 2) and drives it low.
- R5: In TX each packet carries min(MAXP, remaining) bytes, reported on `tx_count` with `cmd_tx_rdy`; the stage becomes TX_END (code 3) when a packet is shorter than MAXP, or when the buffer is used up and no closing zero-length packet was asked for; otherwise the next packet follows each drain event.
- R6: In TX_END a drain event gives data-end and request-done and returns the stage to SETUP.
- R7: In RX a received packet of N bytes is acknowledged with `rx_take` = min(N, remaining); N larger than the remaining space raises `fn_overflow`; a packet whose accepted part is shorter than MAXP, or that fills the buffer, gives data-end and request-done and returns the stage to SETUP.
- R8: A packet received in RX with no buffer handed over is acknowledged together with send-stall, and the stage returns to SETUP.
- R9: A verdict with bit 1 set (stall) gives send-stall; setup-acknowledge comes with it only when the length field is zero; the stage stays SETUP.
- R10: A setup-end abort returns the stage to SETUP and discards any buffer handed over; a setup event in the same cycle is processed as a fresh setup.
- R11: A stall-sent event gives the stall-clear strobe (the write-one-to-clear of the engine's flag) in the next cycle and returns the stage to SETUP.
- R12: A zero-length setup with verdict 1 (delayed) produces no status strobe until `fn_continue` is pulsed; then setup-acknowledge and data-end come together, once.
- R13: A buffer hand-over is refused with `fn_busy` when a buffer is already held or when the stage is not TX or RX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_setup_rdy | input | 1 | Setup packet available (pulse) |
| ev_setup_len | input | 4 | Byte count of the setup packet |
| setup_dir_in | input | 1 | Bit 7 of the request type: 1 = device to host |
| setup_wlength | input | LEN_W | Length field of the setup packet |
| dec_verdict | input | 2 | Decoder class: 0 handled, 1 delayed status, 2 or 3 stall |
| ev_rx_rdy | input | 1 | Data packet received (pulse) |
| rx_count | input | CNT_W | Byte count of the received packet |
| ev_tx_drained | input | 1 | Transmit buffer drained (pulse) |
| ev_setup_end | input | 1 | Running transfer aborted by a new setup (pulse) |
| ev_stall_sent | input | 1 | Stall handshake was sent (pulse) |
| fn_queue | input | 1 | Function layer hands over a buffer (pulse) |
| fn_len | input | LEN_W | Length of the buffer handed over |
| fn_zero | input | 1 | Close a full-packet IN transfer with a zero-length packet |
| fn_continue | input | 1 | Release a held-off status stage (pulse) |
| cmd_setup_ack | output | 1 | Acknowledge the setup packet |
| cmd_data_end | output | 1 | End of data or status stage |
| cmd_send_stall | output | 1 | Send a stall |
| cmd_stall_clr | output | 1 | Clear send-stall and the stall-sent flag |
| cmd_tx_rdy | output | 1 | Packet loaded and ready to send |
| tx_count | output | CNT_W | Byte count of the packet to send |
| cmd_rx_ack | output | 1 | Received packet consumed |
| rx_take | output | CNT_W | Bytes of the received packet that were kept |
| dir_in | output | 1 | Data-stage direction, 1 = device to host |
| fn_done | output | 1 | Buffer handed back complete |
| fn_overflow | output | 1 | Received bytes exceeded the buffer |
| fn_busy | output | 1 | Buffer hand-over refused |
| stage | output | 2 | Current stage: 0 SETUP, 1 TX, 2 RX, 3 TX_END |

## Verification
On every cycle the assertions check the invariants that tie strobes to stages: a packet never exceeds MAXP and a short one always lands in TX_END, a stall or a data-end always leaves the stage at SETUP, an overflow never occurs without the end of the stage, a rejected setup count causes no strobe and a stall-sent event is always followed by the clear. Whether each packet size, each end-of-stage decision and the zero-length-packet rule are right for a given buffer length can only be shown by the bench, which sweeps every IN buffer length from 0 to 20 with and without the closing packet, and every OUT buffer length from 1 to 17 against every packet size from 1 to 9. The abort with a same-cycle setup, the held-off status and the refusal of a second buffer are shown by directed sequences.

// File: rtl/ctrl_ep_pkg.sv
// Shared types for the control endpoint sequencer.
// Assumes: stage codes are seen by the packet engine and the bench, so they are fixed.
package ctrl_ep_pkg;

    // Stage of the control transfer, encoded as seen on the stage port.
    typedef enum logic [1:0] {
        ST_SETUP  = 2'd0,
        ST_TX     = 2'd1,
        ST_RX     = 2'd2,
        ST_TX_END = 2'd3
    } ep_stage_t;

    // Decoder verdict codes; bit 1 set means stall.
    localparam logic [1:0] VD_DONE  = 2'd0;
    localparam logic [1:0] VD_DELAY = 2'd1;

    // A setup packet always carries this many bytes.
    localparam int SETUP_BYTES = 8;
    localparam int SLEN_W      = 4;

endpackage

// File: rtl/ctrl_ep_tx_chunker.sv
// Splits the remaining IN data into the next packet.
// Assumes: rem is the byte count not yet sent; zlp asks for a closing
// zero-length packet when the data ends on a full packet.
module ctrl_ep_tx_chunker #(
    parameter int MAXP  = 64,
    parameter int LEN_W = 16,
    localparam int CNT_W = $clog2(MAXP) + 1
) (
    input  logic [LEN_W-1:0] rem,
    input  logic             zlp,
    output logic [CNT_W-1:0] chunk,
    output logic             last
);
    localparam logic [CNT_W-1:0] MAXP_C = CNT_W'(MAXP);

    logic short_pkt;

    // Size the packet and decide whether it closes the data stage.
    always_comb begin
        chunk     = (rem < LEN_W'(MAXP)) ? rem[CNT_W-1:0] : MAXP_C;
        short_pkt = (chunk < MAXP_C);
        last      = short_pkt || ((rem == LEN_W'(chunk)) && !zlp);
    end
endmodule

// File: rtl/ctrl_ep_rx_accept.sv
// Decides how much of a received OUT packet is kept and whether the stage ends.
// Assumes: rem is the free space left in the buffer handed over.
module ctrl_ep_rx_accept #(
    parameter int MAXP  = 64,
    parameter int LEN_W = 16,
    localparam int CNT_W = $clog2(MAXP) + 1
) (
    input  logic [LEN_W-1:0] rem,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] take,
    output logic             ovf,
    output logic             fin
);
    localparam logic [CNT_W-1:0] MAXP_C = CNT_W'(MAXP);

    logic [LEN_W-1:0] count_ext;

    // Clip the packet to the buffer and detect the end of the stage.
    always_comb begin
        count_ext = LEN_W'(count);
        ovf       = (count_ext > rem);
        take      = ovf ? rem[CNT_W-1:0] : count;
        fin       = (take < MAXP_C) || (count_ext >= rem);
    end
endmodule

// File: rtl/ctrl_ep_seq.sv
// Control endpoint transfer sequencer.
// Sequences setup, data and status stages of endpoint 0 from packet engine
// events and issues registered one-cycle command strobes in return.
// Assumes: events are one-cycle pulses; apart from an abort or stall-sent
// arriving with another event, at most one event comes per cycle; the
// decoder verdict is valid in the cycle of the setup event.
module ctrl_ep_seq
    import ctrl_ep_pkg::*;
#(
    parameter int MAXP  = 64,
    parameter int LEN_W = 16,
    localparam int CNT_W = $clog2(MAXP) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_setup_rdy,
    input  logic [SLEN_W-1:0] ev_setup_len,
    input  logic              setup_dir_in,
    input  logic [LEN_W-1:0]  setup_wlength,
    input  logic [1:0]        dec_verdict,
    input  logic              ev_rx_rdy,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              ev_tx_drained,
    input  logic              ev_setup_end,
    input  logic              ev_stall_sent,
    input  logic              fn_queue,
    input  logic [LEN_W-1:0]  fn_len,
    input  logic              fn_zero,
    input  logic              fn_continue,
    output logic              cmd_setup_ack,
    output logic              cmd_data_end,
    output logic              cmd_send_stall,
    output logic              cmd_stall_clr,
    output logic              cmd_tx_rdy,
    output logic [CNT_W-1:0]  tx_count,
    output logic              cmd_rx_ack,
    output logic [CNT_W-1:0]  rx_take,
    output logic              dir_in,
    output logic              fn_done,
    output logic              fn_overflow,
    output logic              fn_busy,
    output logic [1:0]        stage
);
    localparam logic [CNT_W-1:0] MAXP_C = CNT_W'(MAXP);

    // Registered state.
    ep_stage_t        state_q, state_n;
    logic             pend_q, pend_n;
    logic             dly_q, dly_n;
    logic             zero_q, zero_n;
    logic             dir_q, dir_n;
    logic [LEN_W-1:0] rem_q, rem_n;

    // Next values of the command strobes.
    logic             ack_n, dend_n, stall_n, sclr_n, txr_n, rxa_n;
    logic             done_n, ovf_n, busy_n;
    logic [CNT_W-1:0] txc_n, rxt_n;

    // State after aborts, before the stage logic runs.
    ep_stage_t        st_eff;
    logic             pend_eff, dly_eff;

    // Helper outputs.
    logic [LEN_W-1:0] tx_src;
    logic             tx_zlp;
    logic [CNT_W-1:0] tx_chunk;
    logic             tx_last;
    logic [CNT_W-1:0] rx_keep;
    logic             rx_ovf, rx_fin;
    logic             setup_ok;

    // Pick the byte count the chunker works on: a new buffer or the rest.
    always_comb begin
        tx_src = (state_q == ST_TX && fn_queue && !pend_q) ? fn_len : rem_q;
        tx_zlp = (state_q == ST_TX && fn_queue && !pend_q) ? fn_zero : zero_q;
    end

    ctrl_ep_tx_chunker #(.MAXP(MAXP), .LEN_W(LEN_W)) u_chunker (
        .rem   (tx_src),
        .zlp   (tx_zlp),
        .chunk (tx_chunk),
        .last  (tx_last)
    );

    ctrl_ep_rx_accept #(.MAXP(MAXP), .LEN_W(LEN_W)) u_accept (
        .rem   (rem_q),
        .count (rx_count),
        .take  (rx_keep),
        .ovf   (rx_ovf),
        .fin   (rx_fin)
    );

    assign setup_ok = ev_setup_rdy && (ev_setup_len == SLEN_W'(SETUP_BYTES));

    // Stage transitions and strobe decisions for this cycle's events.
    always_comb begin
        ack_n = 1'b0; dend_n = 1'b0; stall_n = 1'b0; sclr_n = 1'b0;
        txr_n = 1'b0; rxa_n  = 1'b0; done_n  = 1'b0; ovf_n  = 1'b0;
        busy_n = 1'b0;
        txc_n = '0; rxt_n = '0;

        st_eff   = state_q;
        pend_eff = pend_q;
        dly_eff  = dly_q;
        if (ev_stall_sent) begin
            sclr_n  = 1'b1;
            st_eff  = ST_SETUP;
            dly_eff = 1'b0;
        end
        if (ev_setup_end) begin
            st_eff   = ST_SETUP;
            pend_eff = 1'b0;
            dly_eff  = 1'b0;
        end

        state_n = st_eff;
        pend_n  = pend_eff;
        dly_n   = dly_eff;
        zero_n  = zero_q;
        dir_n   = dir_q;
        rem_n   = rem_q;

        case (st_eff)
            ST_SETUP: begin
                if (setup_ok) begin
                    pend_n = 1'b0;
                    dly_n  = 1'b0;
                    if (dec_verdict[1]) begin
                        stall_n = 1'b1;
                        ack_n   = (setup_wlength == '0);
                    end else if (setup_wlength == '0) begin
                        if (dec_verdict == VD_DELAY) begin
                            dly_n = 1'b1;
                        end else begin
                            ack_n  = 1'b1;
                            dend_n = 1'b1;
                        end
                    end else begin
                        ack_n   = 1'b1;
                        dir_n   = setup_dir_in;
                        state_n = setup_dir_in ? ST_TX : ST_RX;
                    end
                end else if (dly_eff && fn_continue) begin
                    ack_n  = 1'b1;
                    dend_n = 1'b1;
                    dly_n  = 1'b0;
                end else if (fn_queue) begin
                    busy_n = 1'b1;
                end
            end
            ST_TX: begin
                if (fn_queue && pend_eff) begin
                    busy_n = 1'b1;
                end else if (fn_queue || (ev_tx_drained && pend_eff)) begin
                    pend_n = 1'b1;
                    zero_n = tx_zlp;
                    txr_n  = 1'b1;
                    txc_n  = tx_chunk;
                    rem_n  = tx_src - LEN_W'(tx_chunk);
                    if (tx_last) state_n = ST_TX_END;
                end
            end
            ST_TX_END: begin
                if (fn_queue) begin
                    busy_n = 1'b1;
                end else if (ev_tx_drained) begin
                    dend_n  = 1'b1;
                    done_n  = 1'b1;
                    pend_n  = 1'b0;
                    state_n = ST_SETUP;
                end
            end
            ST_RX: begin
                if (fn_queue) begin
                    if (pend_eff) begin
                        busy_n = 1'b1;
                    end else begin
                        pend_n = 1'b1;
                        rem_n  = fn_len;
                    end
                end else if (ev_rx_rdy) begin
                    rxa_n = 1'b1;
                    if (!pend_eff) begin
                        stall_n = 1'b1;
                        state_n = ST_SETUP;
                    end else begin
                        rxt_n = rx_keep;
                        ovf_n = rx_ovf;
                        rem_n = rem_q - LEN_W'(rx_keep);
                        if (rx_fin) begin
                            dend_n  = 1'b1;
                            done_n  = 1'b1;
                            pend_n  = 1'b0;
                            state_n = ST_SETUP;
                        end
                    end
                end
            end
            default: state_n = ST_SETUP;
        endcase
    end

    // Register the stage state and all command outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= ST_SETUP;
            pend_q         <= 1'b0;
            dly_q          <= 1'b0;
            zero_q         <= 1'b0;
            dir_q          <= 1'b0;
            rem_q          <= '0;
            cmd_setup_ack  <= 1'b0;
            cmd_data_end   <= 1'b0;
            cmd_send_stall <= 1'b0;
            cmd_stall_clr  <= 1'b0;
            cmd_tx_rdy     <= 1'b0;
            tx_count       <= '0;
            cmd_rx_ack     <= 1'b0;
            rx_take        <= '0;
            fn_done        <= 1'b0;
            fn_overflow    <= 1'b0;
            fn_busy        <= 1'b0;
        end else begin
            state_q        <= state_n;
            pend_q         <= pend_n;
            dly_q          <= dly_n;
            zero_q         <= zero_n;
            dir_q          <= dir_n;
            rem_q          <= rem_n;
            cmd_setup_ack  <= ack_n;
            cmd_data_end   <= dend_n;
            cmd_send_stall <= stall_n;
            cmd_stall_clr  <= sclr_n;
            cmd_tx_rdy     <= txr_n;
            tx_count       <= txc_n;
            cmd_rx_ack     <= rxa_n;
            rx_take        <= rxt_n;
            fn_done        <= done_n;
            fn_overflow    <= ovf_n;
            fn_busy        <= busy_n;
        end
    end

    assign stage  = state_q;
    assign dir_in = dir_q;

    // Packets never exceed MAXP, and a short one always closes the data stage.
    assert_tx_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_tx_rdy |-> (tx_count <= MAXP_C) &&
                       ((tx_count == MAXP_C) || (stage == ST_TX_END)));

    // A stall is always followed by the SETUP stage.
    assert_stall_to_setup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_send_stall |-> (stage == ST_SETUP));

    // Data-end on an OUT packet returns to SETUP; overflow only with end of stage.
    assert_rx_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rx_ack && cmd_data_end) |-> (stage == ST_SETUP));
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fn_overflow |-> (cmd_data_end && cmd_rx_ack));

    // A setup of the wrong size produces no strobe.
    assert_bad_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_setup_rdy && ev_setup_len != SLEN_W'(SETUP_BYTES) && !ev_setup_end &&
         !ev_stall_sent && !fn_continue && state_q == ST_SETUP)
        |=> (!cmd_setup_ack && !cmd_send_stall && !cmd_data_end && stage == ST_SETUP));

    // A stall-sent event always clears the stall in the next cycle.
    assert_stall_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stall_sent |=> (cmd_stall_clr && stage == ST_SETUP));

    // Only one of the packet-level handshakes per cycle.
    assert_one_handshake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_tx_rdy, cmd_rx_ack, cmd_stall_clr}));
endmodule

// File: tb/test_ctrl_ep_seq.sv
`timescale 1ns/1ps
module test_ctrl_ep_seq;
    localparam int MAXP  = 8;
    localparam int LEN_W = 16;
    localparam int CNT_W = $clog2(MAXP) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic             ev_setup_rdy = 0;
    logic [3:0]       ev_setup_len = 0;
    logic             setup_dir_in = 0;
    logic [LEN_W-1:0] setup_wlength = 0;
    logic [1:0]       dec_verdict = 0;
    logic             ev_rx_rdy = 0;
    logic [CNT_W-1:0] rx_count = 0;
    logic             ev_tx_drained = 0;
    logic             ev_setup_end = 0;
    logic             ev_stall_sent = 0;
    logic             fn_queue = 0;
    logic [LEN_W-1:0] fn_len = 0;
    logic             fn_zero = 0;
    logic             fn_continue = 0;
    logic             cmd_setup_ack, cmd_data_end, cmd_send_stall, cmd_stall_clr;
    logic             cmd_tx_rdy, cmd_rx_ack, dir_in, fn_done, fn_overflow, fn_busy;
    logic [CNT_W-1:0] tx_count, rx_take;
    logic [1:0]       stage;

    ctrl_ep_seq #(.MAXP(MAXP), .LEN_W(LEN_W)) i_ctrl_ep_seq (
        .clk, .rst_n, .ev_setup_rdy, .ev_setup_len, .setup_dir_in, .setup_wlength,
        .dec_verdict, .ev_rx_rdy, .rx_count, .ev_tx_drained, .ev_setup_end,
        .ev_stall_sent, .fn_queue, .fn_len, .fn_zero, .fn_continue,
        .cmd_setup_ack, .cmd_data_end, .cmd_send_stall, .cmd_stall_clr,
        .cmd_tx_rdy, .tx_count, .cmd_rx_ack, .rx_take, .dir_in, .fn_done,
        .fn_overflow, .fn_busy, .stage
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Wait for an edge, then settle away from it.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic clr_ev();
        ev_setup_rdy = 0; ev_rx_rdy = 0; ev_tx_drained = 0; ev_setup_end = 0;
        ev_stall_sent = 0; fn_queue = 0; fn_continue = 0;
    endtask

    task automatic t_setup(int len, bit din, int wlen, int vd);
        ev_setup_rdy = 1; ev_setup_len = 4'(len); setup_dir_in = din;
        setup_wlength = LEN_W'(wlen); dec_verdict = 2'(vd);
        tick(); clr_ev();
    endtask

    task automatic t_queue(int len, bit z);
        fn_queue = 1; fn_len = LEN_W'(len); fn_zero = z;
        tick(); clr_ev();
    endtask

    task automatic t_rx(int n);
        ev_rx_rdy = 1; rx_count = CNT_W'(n);
        tick(); clr_ev();
    endtask

    task automatic t_drain();
        ev_tx_drained = 1; tick(); clr_ev();
    endtask

    int strobes;
    function automatic int all_strobes();
        return int'(cmd_setup_ack) + int'(cmd_data_end) + int'(cmd_send_stall) +
               int'(cmd_stall_clr) + int'(cmd_tx_rdy) + int'(cmd_rx_ack) +
               int'(fn_done) + int'(fn_overflow) + int'(fn_busy);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) tick();
        // R1: reset state
        chk("R1", "stage", stage, 0);
        chk("R1", "strobes", all_strobes(), 0);
        chk("R1", "dir_in", dir_in, 0);
        rst_n = 1;
        tick();

        // R2: wrong setup sizes are ignored
        t_setup(7, 1, 16, 0);
        chk("R2", "strobes len7", all_strobes(), 0);
        chk("R2", "stage len7", stage, 0);
        t_setup(9, 0, 0, 0);
        chk("R2", "strobes len9", all_strobes(), 0);
        chk("R2", "stage len9", stage, 0);

        // R3: no data stage, handled
        t_setup(8, 0, 0, 0);
        chk("R3", "ack", cmd_setup_ack, 1);
        chk("R3", "data_end", cmd_data_end, 1);
        chk("R3", "stage", stage, 0);
        tick();
        chk("R3", "strobes one cycle", all_strobes(), 0);

        // R12: delayed status
        t_setup(8, 0, 0, 1);
        chk("R12", "no status yet", all_strobes(), 0);
        tick();
        chk("R12", "still held", all_strobes(), 0);
        fn_continue = 1; tick(); clr_ev();
        chk("R12", "ack on continue", cmd_setup_ack, 1);
        chk("R12", "data_end on continue", cmd_data_end, 1);
        fn_continue = 1; tick(); clr_ev();
        chk("R12", "second continue", cmd_setup_ack + cmd_data_end, 0);

        // R9: stall with and without data stage
        t_setup(8, 0, 0, 2);
        chk("R9", "stall no-data", cmd_send_stall, 1);
        chk("R9", "ack no-data", cmd_setup_ack, 1);
        chk("R9", "stage", stage, 0);
        t_setup(8, 1, 10, 3);
        chk("R9", "stall data", cmd_send_stall, 1);
        chk("R9", "ack data", cmd_setup_ack, 0);
        chk("R9", "stage data", stage, 0);

        // R13: hand-over in SETUP refused
        t_queue(4, 0);
        chk("R13", "busy in SETUP", fn_busy, 1);

        // R8: OUT packet without a buffer
        t_setup(8, 0, 10, 0);
        chk("R4", "stage RX", stage, 2);
        chk("R4", "dir out", dir_in, 0);
        t_rx(3);
        chk("R8", "rx_ack", cmd_rx_ack, 1);
        chk("R8", "stall", cmd_send_stall, 1);
        chk("R8", "stage", stage, 0);

        // R11: stall-sent from TX
        t_setup(8, 1, 10, 0);
        chk("R4", "stage TX", stage, 1);
        chk("R4", "dir in", dir_in, 1);
        ev_stall_sent = 1; tick(); clr_ev();
        chk("R11", "stall_clr", cmd_stall_clr, 1);
        chk("R11", "stage", stage, 0);

        // R13 and R10: busy, then abort with a same-cycle setup
        t_setup(8, 1, 40, 0);
        t_queue(20, 0);
        chk("R5", "first chunk", tx_count, 8);
        t_queue(5, 0);
        chk("R13", "busy second buffer", fn_busy, 1);
        chk("R13", "no packet on refusal", cmd_tx_rdy, 0);
        ev_setup_end = 1; ev_setup_rdy = 1; ev_setup_len = 8; setup_dir_in = 0;
        setup_wlength = 4; dec_verdict = 0;
        tick(); clr_ev();
        chk("R10", "new stage RX", stage, 2);
        chk("R10", "ack", cmd_setup_ack, 1);
        t_rx(4);
        chk("R10", "old buffer dropped", cmd_send_stall, 1);

        // R5/R6: IN sweep over buffer length and zero-length rule
        for (int len = 0; len <= 20; len++) begin
            for (int z = 0; z < 2; z++) begin
                int rem;
                t_setup(8, 1, 64, 0);
                rem = len;
                fn_queue = 1; fn_len = LEN_W'(len); fn_zero = z[0];
                tick(); clr_ev();
                for (int k = 0; k < 10; k++) begin
                    int c;
                    bit last;
                    c = (rem < MAXP) ? rem : MAXP;
                    last = (c < MAXP) || (rem == c && z == 0);
                    chk("R5", "tx_rdy", cmd_tx_rdy, 1);
                    chk("R5", "tx_count", tx_count, c);
                    chk("R5", "stage", stage, last ? 3 : 1);
                    rem -= c;
                    t_drain();
                    if (last) break;
                end
                chk("R6", "data_end", cmd_data_end, 1);
                chk("R6", "done", fn_done, 1);
                chk("R6", "stage", stage, 0);
            end
        end

        // R7: OUT sweep over buffer length and packet size
        for (int b = 1; b <= 17; b++) begin
            for (int p = 1; p <= 9; p++) begin
                int rem;
                t_setup(8, 0, 64, 0);
                t_queue(b, 0);
                chk("R13", "accept in RX", fn_busy, 0);
                rem = b;
                for (int k = 0; k < 20; k++) begin
                    int tk;
                    bit ov, fin;
                    ov = (p > rem);
                    tk = ov ? rem : p;
                    fin = (tk < MAXP) || (p >= rem);
                    t_rx(p);
                    chk("R7", "rx_ack", cmd_rx_ack, 1);
                    chk("R7", "rx_take", rx_take, tk);
                    chk("R7", "overflow", fn_overflow, ov);
                    chk("R7", "data_end", cmd_data_end, fin);
                    chk("R7", "stage", stage, fin ? 0 : 2);
                    rem -= tk;
                    if (fin) break;
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule